// File: doc/BRIEF.md
# Synchronous Shift-Clock Serial Port

This block is a byte-wide serial port that runs in synchronous shift-register mode. It moves data in both directions over one data pin, one direction at a time. A second pin carries a shift clock that the port always generates itself. Each bit takes twelve cycles of the input clock: the shift clock is low for the first half of that period and high for the second half. Data is sent least-significant bit first.

Software sees a single buffer location. A write to that location loads the transmit shifter and starts a frame on the next clock. Reads always return the receive holding register, so a write never changes what a read returns. A reception starts on its own whenever the port is idle, the receive-enable input is high and the receive-done flag is clear. Once a byte has arrived, no further reception starts until software clears that flag. Both done flags stay set until software clears them with a pulse.

The data pin is split into an input, an output and an output enable, so the pad can be built outside the block. The enable is high only while a byte is being sent. Otherwise the pin is released so that an external shift register can drive it during a reception.

Top module: `sync_shift_port`

## Requirements
- R1: After reset, sclk_out is 1, sdata_oe is 0, tx_done and rx_done are 0 and rd_data is 0x00.
- R2: A cycle with wr_en high starts a transmit frame at that edge, even when a reception is in progress. At the next edge, sdata_oe becomes 1 and sclk_out becomes 0. Bit k of the written byte (k = 0 first, then 1 up to 7) appears on sdata_out for clock cycles 12k to 12k+11 after that edge.
- R3: Within each bit, sclk_out is low for 6 clock cycles and then high for 6. Consecutive rising edges of sclk_out within a frame are exactly 12 clock cycles apart.
- R4: tx_done becomes 1 at the 96th edge after the write edge, and sclk_out is 1 from that edge on. tx_done stays 1 until a cycle with tx_done_clr high clears it.
- R5: A write never changes rd_data. rd_data changes only at the edge where rx_done is set.
- R6: A reception starts when the port is idle, rx_enable is 1, rx_done is 0 and wr_en is 0. sdata_oe stays 0 throughout the reception.
- R7: During a reception, sdata_in is captured on each rising edge of sclk_out. The first captured bit becomes bit 0. At the end of the eighth bit period, rx_done is set and rd_data holds the assembled byte.
- R8: While rx_done is 1, or while rx_enable is 0, no reception starts: sclk_out stays high and rd_data is unchanged.
- R9: A write during a reception abandons the reception. The written byte is transmitted intact, and rx_done and rd_data are not changed.
- R10: sdata_oe is 1 only during a transmit frame. It returns to 0 at the edge where tx_done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; twelve cycles make one bit period |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the buffer location; starts transmission |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Receive holding register, returned by buffer reads |
| rx_enable | input | 1 | Receive-enable control bit |
| tx_done | output | 1 | Transmit-complete flag |
| tx_done_clr | input | 1 | Pulse that clears tx_done |
| rx_done | output | 1 | Receive-complete flag |
| rx_done_clr | input | 1 | Pulse that clears rx_done |
| sdata_in | input | 1 | Data pin input from the pad |
| sdata_out | output | 1 | Data pin output value |
| sdata_oe | output | 1 | Data pin output enable, high only while transmitting |
| sclk_out | output | 1 | Shift clock; idles high |

## Verification
The hardest situations to reach are the ones where reception must not happen. The first is a port that is idle and enabled but still holds rx_done, with an external device ready to send. The second is a write that arrives in the middle of a reception. To reach the first, the bench leaves the modelled external shift register armed after a byte completes and keeps rx_enable high. It then counts falling edges of the shift clock over a long window, and there must be none. To reach the second, it arms the device, lets a reception run partway, drops rx_enable and writes a byte. The transmitted bits are then checked against the scoreboard, and rx_done and rd_data must be unchanged.

// File: rtl/sync_shift_pkg.sv
package sync_shift_pkg;
  typedef enum logic [1:0] {
    SSP_IDLE = 2'd0,
    SSP_TX   = 2'd1,
    SSP_RX   = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ssp_bit_timer.sv
// Bit-period and bit-index counter shared by transmit and receive.
module ssp_bit_timer #(
  parameter int DIV   = 12,
  parameter int NBITS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic bit_end,
  output logic frame_end,
  output logic sample,
  output logic sclk_hi_next
);
  localparam int CW   = $clog2(DIV) + 1;
  localparam int BW   = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam int HALF = DIV / 2;

  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [CW-1:0] cnt_inc;

  assign cnt_inc      = cnt + CW'(1);
  assign bit_end      = run && (cnt == CW'(DIV - 1));
  assign frame_end    = bit_end && (bidx == BW'(NBITS - 1));
  assign sample       = run && (cnt == CW'(HALF - 1));
  assign sclk_hi_next = bit_end ? 1'b0 : (cnt_inc >= CW'(HALF));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt  <= '0;
      bidx <= '0;
    end else if (run) begin
      if (bit_end) begin
        cnt  <= '0;
        bidx <= frame_end ? '0 : bidx + BW'(1);
      end else begin
        cnt <= cnt_inc;
      end
    end
  end
endmodule

// File: rtl/ssp_tx_shifter.sv
// Transmit shifter: presents the LSB and moves right at each bit boundary.
module ssp_tx_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [NBITS-1:0] load_data,
  input  logic             advance,
  output logic             bit_out
);
  logic [NBITS-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)          sh <= '1;
    else if (load)    sh <= load_data;
    else if (advance) sh <= {1'b1, sh[NBITS-1:1]};
  end

  assign bit_out = sh[0];
endmodule

// File: rtl/ssp_rx_shifter.sv
// Receive shifter: the first bit captured ends up in bit 0.
module ssp_rx_shifter #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic             bit_in,
  output logic [NBITS-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)          word <= '0;
    else if (capture) word <= {bit_in, word[NBITS-1:1]};
  end
endmodule

// File: rtl/ssp_flags.sv
// Done flags and the receive holding register. A set wins over a clear.
module ssp_flags #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_set,
  input  logic             tx_clr,
  input  logic             rx_set,
  input  logic             rx_clr,
  input  logic [NBITS-1:0] rx_word,
  output logic             tx_done,
  output logic             rx_done,
  output logic [NBITS-1:0] hold
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      hold    <= '0;
    end else begin
      if (tx_set)      tx_done <= 1'b1;
      else if (tx_clr) tx_done <= 1'b0;
      if (rx_set) begin
        rx_done <= 1'b1;
        hold    <= rx_word;
      end else if (rx_clr) begin
        rx_done <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port #(
  parameter int DIV   = 12,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NBITS-1:0] wr_data,
  output logic [NBITS-1:0] rd_data,
  input  logic             rx_enable,
  output logic             tx_done,
  input  logic             tx_done_clr,
  output logic             rx_done,
  input  logic             rx_done_clr,
  input  logic             sdata_in,
  output logic             sdata_out,
  output logic             sdata_oe,
  output logic             sclk_out
);
  import sync_shift_pkg::*;

  ssp_state_e       state;
  logic             start_tx, start_rx, start_any, running;
  logic             bit_end, frame_end, sample, sclk_hi_next;
  logic             tx_bit;
  logic [NBITS-1:0] rx_word;

  assign start_tx  = wr_en;
  assign start_rx  = (state == SSP_IDLE) && rx_enable && !rx_done && !wr_en;
  assign start_any = start_tx || start_rx;
  assign running   = (state != SSP_IDLE) && !start_any;

  ssp_bit_timer #(.DIV(DIV), .NBITS(NBITS)) u_timer (
    .clk(clk), .rst(rst), .start(start_any), .run(running),
    .bit_end(bit_end), .frame_end(frame_end), .sample(sample),
    .sclk_hi_next(sclk_hi_next)
  );

  ssp_tx_shifter #(.NBITS(NBITS)) u_tx (
    .clk(clk), .rst(rst), .load(start_tx), .load_data(wr_data),
    .advance(running && (state == SSP_TX) && bit_end && !frame_end),
    .bit_out(tx_bit)
  );

  ssp_rx_shifter #(.NBITS(NBITS)) u_rx (
    .clk(clk), .rst(rst),
    .capture(running && (state == SSP_RX) && sample),
    .bit_in(sdata_in), .word(rx_word)
  );

  ssp_flags #(.NBITS(NBITS)) u_flags (
    .clk(clk), .rst(rst),
    .tx_set(running && (state == SSP_TX) && frame_end),
    .tx_clr(tx_done_clr),
    .rx_set(running && (state == SSP_RX) && frame_end),
    .rx_clr(rx_done_clr),
    .rx_word(rx_word),
    .tx_done(tx_done), .rx_done(rx_done), .hold(rd_data)
  );

  // Sequencer and the registered pin outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SSP_IDLE;
      sclk_out <= 1'b1;
      sdata_oe <= 1'b0;
    end else if (start_tx) begin
      state    <= SSP_TX;
      sclk_out <= 1'b0;
      sdata_oe <= 1'b1;
    end else if (start_rx) begin
      state    <= SSP_RX;
      sclk_out <= 1'b0;
      sdata_oe <= 1'b0;
    end else if (running) begin
      if (frame_end) begin
        state    <= SSP_IDLE;
        sclk_out <= 1'b1;
        sdata_oe <= 1'b0;
      end else begin
        sclk_out <= sclk_hi_next;
      end
    end else begin
      sclk_out <= 1'b1;
      sdata_oe <= 1'b0;
    end
  end

  assign sdata_out = tx_bit;
endmodule

// File: rtl/sync_shift_port_chk.sv
module sync_shift_port_chk #(
  parameter int DIV   = 12,
  parameter int NBITS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rx_enable,
  input logic             rx_done,
  input logic             rx_done_clr,
  input logic             tx_done,
  input logic             tx_done_clr,
  input logic             sclk_out,
  input logic             sdata_oe,
  input logic [NBITS-1:0] rd_data,
  input logic [1:0]       state
);
  localparam int HALF = DIV / 2;
  localparam int LW   = $clog2(DIV) + 2;

  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || sclk_out || wr_en) low_run <= '0;
    else if (low_run != '1)       low_run <= low_run + LW'(1);
  end

  // R2: a write brings the pin enable up and the clock low next cycle
  a_r2_write_starts: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (sdata_oe && !sclk_out));

  // R3: a low phase of the shift clock never lasts longer than half a bit
  a_r3_low_phase: assert property (@(posedge clk) disable iff (rst)
    !sclk_out |-> (low_run <= LW'(HALF - 1)));

  // R4: the transmit flag holds until it is cleared
  a_r4_txdone_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_done && !tx_done_clr) |=> tx_done);

  // R5: the holding register changes only when a reception completes
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !$stable(rd_data) |-> $rose(rx_done));

  // R8: an idle port holding rx_done, or not enabled, keeps the clock high
  a_r8_no_rx_gate: assert property (@(posedge clk) disable iff (rst)
    ((state == 2'd0) && !wr_en && (rx_done || !rx_enable)) |=> sclk_out);

  // R10: the pin is never driven while idle
  a_r10_oe_idle: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0) |-> !sdata_oe);
endmodule

bind sync_shift_port sync_shift_port_chk #(.DIV(DIV), .NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rx_enable(rx_enable),
  .rx_done(rx_done), .rx_done_clr(rx_done_clr), .tx_done(tx_done),
  .tx_done_clr(tx_done_clr), .sclk_out(sclk_out), .sdata_oe(sdata_oe),
  .rd_data(rd_data), .state(state)
);

// File: tb/test_sync_shift_port.sv
module test_sync_shift_port;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       rx_enable = 1'b0;
  logic       tx_done, rx_done;
  logic       tx_done_clr = 1'b0;
  logic       rx_done_clr = 1'b0;
  logic       sdata_in = 1'b1;
  logic       sdata_out, sdata_oe, sclk_out;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 1'b0;

  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_shift_port i_sync_shift_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .rx_enable(rx_enable), .tx_done(tx_done), .tx_done_clr(tx_done_clr),
    .rx_done(rx_done), .rx_done_clr(rx_done_clr), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .sclk_out(sclk_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // cycle counter on the falling edge, where every output is settled
  int cyc = 0;
  always @(negedge clk) cyc++;

  // Monitor: external shift register capturing transmitted bits
  int         mon_bits = 0;
  int         last_rise = 0;
  logic [7:0] mon_byte = 8'h00;
  always @(posedge sclk_out) begin
    if (sdata_oe) begin
      if (mon_bits > 0)
        check((cyc - last_rise) == 12, "R3 rise spacing", cyc - last_rise, 12);
      last_rise = cyc;
      mon_byte = {sdata_out, mon_byte[7:1]};
      mon_bits++;
      if (mon_bits == 8) begin
        mon_bits = 0;
        if (tx_q.size() == 0) check(1'b0, "R2 unexpected frame", mon_byte, 0);
        else begin
          logic [7:0] e;
          e = tx_q.pop_front();
          check(mon_byte == e, "R2 tx byte LSB first", mon_byte, e);
        end
      end
    end
  end

  // External device: drives a new bit after each falling shift clock
  bit         dev_armed = 1'b0;
  logic [7:0] dev_byte = 8'h00;
  int         dev_idx = 0;
  int         falls = 0;
  always @(negedge sclk_out) begin
    falls++;
    if (dev_armed && !sdata_oe && dev_idx < 8) begin
      sdata_in = dev_byte[dev_idx];
      dev_idx++;
    end
  end

  // Receive scoreboard
  always @(posedge rx_done) begin
    @(negedge clk);
    if (rx_q.size() == 0) check(1'b0, "R7 unexpected rx", rd_data, 0);
    else begin
      logic [7:0] e;
      e = rx_q.pop_front();
      check(rd_data == e, "R7 rx byte", rd_data, e);
    end
  end

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    tx_q.push_back(b);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    tx_done_clr = 1'b1; rx_done_clr = 1'b1;
    @(negedge clk);
    tx_done_clr = 1'b0; rx_done_clr = 1'b0;
  endtask

  task automatic arm_device(input logic [7:0] b);
    dev_byte = b; dev_idx = 0; dev_armed = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(sclk_out == 1'b1, "R1 sclk idle", sclk_out, 1);
    check(sdata_oe == 1'b0, "R1 oe", sdata_oe, 0);
    check(tx_done == 1'b0 && rx_done == 1'b0, "R1 flags", {tx_done, rx_done}, 0);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);

    // R2/R3/R4/R10: cycle-exact frame timing
    write_byte(8'hA5);
    check(sdata_oe && !sclk_out, "R2 start", {sdata_oe, sclk_out}, 2);
    check(sdata_out == 1'b1, "R2 bit0 on pin", sdata_out, 1);
    repeat (5) @(negedge clk);
    check(sclk_out == 1'b0, "R3 low phase end", sclk_out, 0);
    @(negedge clk);
    check(sclk_out == 1'b1, "R3 high phase", sclk_out, 1);
    repeat (6) @(negedge clk);
    check(sdata_out == 1'b0 && !sclk_out, "R2 bit1 on pin", sdata_out, 0);
    repeat (83) @(negedge clk);
    check(tx_done == 1'b0, "R4 not yet done", tx_done, 0);
    check(sdata_oe == 1'b1, "R10 oe during frame", sdata_oe, 1);
    @(negedge clk);
    check(tx_done == 1'b1, "R4 done at 96", tx_done, 1);
    check(sclk_out && !sdata_oe, "R10 release", {sclk_out, sdata_oe}, 2);
    repeat (20) @(negedge clk);
    check(tx_done == 1'b1, "R4 flag held", tx_done, 1);
    clear_flags();
    check(tx_done == 1'b0, "R4 cleared", tx_done, 0);

    write_byte(8'h01);
    repeat (100) @(negedge clk);
    write_byte(8'h80);
    repeat (100) @(negedge clk);
    check(rd_data == 8'h00, "R5 write leaves rd_data", rd_data, 0);
    clear_flags();

    // R6/R7: reception from the external device
    arm_device(8'h3C);
    rx_q.push_back(8'h3C);
    @(negedge clk);
    rx_enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!sclk_out && !sdata_oe, "R6 rx started, pin released", {sclk_out, sdata_oe}, 0);
    wait (rx_done == 1'b1);
    repeat (3) @(negedge clk);

    // R8: rx_done still set, device still armed, enable high
    dev_idx = 0;
    f0 = falls;
    held = rd_data;
    repeat (300) @(negedge clk);
    check(falls == f0, "R8 no clock while rx_done", falls - f0, 0);
    check(rd_data == held, "R8 rd_data held", rd_data, held);

    // R8: enable low, flag cleared
    rx_enable = 1'b0;
    clear_flags();
    f0 = falls;
    repeat (300) @(negedge clk);
    check(falls == f0, "R8 no clock while disabled", falls - f0, 0);

    // second reception with a different pattern
    arm_device(8'hD2);
    rx_q.push_back(8'hD2);
    rx_enable = 1'b1;
    wait (rx_done == 1'b1);
    rx_enable = 1'b0;
    repeat (3) @(negedge clk);
    clear_flags();

    // R9: write during reception
    held = rd_data;
    arm_device(8'hFF);
    rx_enable = 1'b1;
    repeat (30) @(negedge clk);
    rx_enable = 1'b0;
    dev_armed = 1'b0;
    write_byte(8'h5A);
    repeat (110) @(negedge clk);
    check(rx_done == 1'b0, "R9 rx abandoned", rx_done, 0);
    check(rd_data == held, "R9 rd_data kept", rd_data, held);
    check(tx_done == 1'b1, "R9 tx completed", tx_done, 1);

    repeat (5) @(negedge clk);
    check(tx_q.size() == 0, "R2 all frames seen", tx_q.size(), 0);
    check(rx_q.size() == 0, "R7 all bytes seen", rx_q.size(), 0);
    finish_run();
  end
endmodule